// File: doc/BRIEF.md
# Effects DSP Microprogram Sequencer

This block sequences an effects DSP program held in a writable control store of 32-bit microinstructions. Every audio sample frame it runs a fixed program of 64 instructions, and each instruction takes a fixed slot of 8 clock phases, so a frame is 512 clocks long. The sequencer hands the current microinstruction to the arithmetic datapath. For instructions that touch delay memory, it also issues one memory request carrying an address and a read or write flag.

The delay-memory address is a circular base pointer plus the instruction's own 16-bit offset. When the instruction asks for it, an externally generated modulation (LFO) value is added as well, and the sum wraps at the memory size. The base pointer steps down by one each frame, so every delay tap rotates through memory. A host loads the control store through a simple write port at any time. Edits made during a frame are staged and take effect together at the next frame boundary, so a running program never executes a half-edited frame.

Top module: `dsp_useq`

## Requirements
- R1: The instruction index `pc_o` steps 0 to 63, advancing once per instruction, and wraps from 63 back to 0.
- R2: `phase_o` counts 0 to 7 within every instruction, so each frame lasts exactly 512 clock cycles.
- R3: `frame_o` is high for exactly one cycle per frame: the cycle with instruction 0 in phase 0.
- R4: Microinstruction layout: bits 31:16 hold an unsigned offset, bit 15 enables modulation, bit 14 selects write, and bit 13 enables memory access. Bits 12:0 are ignored. A request (`mem_req_o` high) appears only in phase 1, and only when bit 13 is set.
- R5: `mem_we_o` is high only together with a request whose instruction has bit 14 set. Bit 14 without bit 13 produces no request.
- R6: The request address is base + offset, taken modulo 2^16 (`ADDR_W`).
- R7: When bit 15 is set, the value on `lfo_i` in the instruction's phase 0 is added to the address as a two's-complement number. When bit 15 is clear, `lfo_i` has no effect.
- R8: The base is 0 in the first frame after reset and falls by one at each frame boundary, wrapping from 0 to 0xFFFF.
- R9: The word 0x00000303 decodes as a no-operation: no request and no write.
- R10: A host write made during a frame does not change that frame's remaining instructions, and takes effect from the next frame.
- R11: A host write in the last cycle of a frame, or while reset is asserted, takes effect in the frame that follows.
- R12: While `rst` is high, `pc_o` and `phase_o` stay 0 and `frame_o` and `mem_req_o` stay low. Reset returns the base to 0 and keeps the control store contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we_i | input | 1 | Host control-store write strobe |
| host_addr_i | input | 6 | Control-store entry to write |
| host_data_i | input | 32 | Microinstruction to write |
| lfo_i | input | 16 | Signed modulation displacement |
| frame_o | output | 1 | Start-of-frame strobe |
| pc_o | output | 6 | Current instruction index |
| phase_o | output | 3 | Current phase within the instruction |
| instr_o | output | 32 | Current microinstruction for the datapath |
| mem_req_o | output | 1 | Delay-memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 16 | Delay-memory address |

## Verification
The assertions rely on three properties of the inputs. Reset is synchronous and is held across at least one rising edge. At most one host write arrives per cycle. `lfo_i` only needs to be valid at the end of phase 0, because the address logic samples it there. The stimulus meets all three by changing every input only on falling edges. It holds `lfo_i` constant across each instruction and issues single-cycle host writes. It aims the two deliberate edits at a mid-frame cycle and at the final cycle of a frame, so the staging and forwarding paths are both exercised within these limits.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UWORD_W = 32;
  localparam int OFFS_W  = 16;
  localparam int RSVD_W  = 13;

  // Microinstruction layout, MSB first.
  typedef struct packed {
    logic [OFFS_W-1:0] offset;   // unsigned delay offset
    logic              lfo_en;   // add modulation displacement
    logic              wr;       // access is a write
    logic              acc;      // access delay memory
    logic [RSVD_W-1:0] rsvd;     // ignored by the sequencer
  } uword_t;

  localparam logic [UWORD_W-1:0] UWORD_NOP = 32'h0000_0303;

endpackage

// File: rtl/useq_timer.sv
module useq_timer #(
  parameter int N_INSTR = 64,
  parameter int N_PHASE = 8,
  localparam int PC_W = $clog2(N_INSTR),
  localparam int PH_W = $clog2(N_PHASE)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] pc_o,
  output logic [PH_W-1:0] phase_o,
  output logic            fetch_en_o,
  output logic [PC_W-1:0] fetch_addr_o,
  output logic            frame_end_o,
  output logic            issue_o
);

  localparam logic [PC_W-1:0] PC_LAST = PC_W'(N_INSTR - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(N_PHASE - 1);

  logic [PC_W-1:0] pc_q;
  logic [PH_W-1:0] phase_q;
  logic            slot_end;

  assign slot_end = (phase_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      phase_q <= '0;
    end else begin
      phase_q <= slot_end ? '0 : phase_q + 1'b1;
      if (slot_end) begin
        pc_q <= (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
      end
    end
  end

  // The next word is fetched in the last phase so it is valid from phase 0.
  assign fetch_en_o   = rst | slot_end;
  assign fetch_addr_o = (rst || pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
  assign frame_end_o  = !rst && slot_end && (pc_q == PC_LAST);
  assign issue_o      = !rst && (phase_q == '0);
  assign pc_o         = pc_q;
  assign phase_o      = phase_q;

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    slot_end |=> (phase_q == '0)); // R2
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !slot_end |=> $stable(pc_q)); // R1
  AST_PC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (slot_end && pc_q == PC_LAST) |=> (pc_q == '0)); // R1

endmodule

// File: rtl/useq_cstore.sv
module useq_cstore #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary_i,
  input  logic              host_we_i,
  input  logic [IDX_W-1:0]  host_addr_i,
  input  logic [WORD_W-1:0] host_data_i,
  input  logic              fetch_en_i,
  input  logic [IDX_W-1:0]  fetch_addr_i,
  output logic [WORD_W-1:0] word_o
);

  // Per-entry bank select and pending flags; never reset so a reset keeps the program.
  logic [DEPTH-1:0]  sel_q  = '0;
  logic [DEPTH-1:0]  pend_q = '0;
  logic [DEPTH-1:0]  wmask, sel_nxt, pend_nxt;
  logic              commit, tgt_bank;
  logic              bsel_q, fwd_q;
  logic [WORD_W-1:0] fwd_data_q;

  always_comb begin
    wmask = '0;
    if (host_we_i) wmask[host_addr_i] = 1'b1;
  end

  // Reset cycles behave like a frame boundary: staged edits become live.
  assign commit   = rst | boundary_i;
  assign sel_nxt  = commit ? (sel_q ^ (pend_q | wmask)) : sel_q;
  assign pend_nxt = commit ? '0 : (pend_q | wmask);
  assign tgt_bank = ~sel_q[host_addr_i];

  always_ff @(posedge clk) begin
    sel_q  <= sel_nxt;
    pend_q <= pend_nxt;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_q;
    logic              wr_en;
    assign wr_en = host_we_i && (tgt_bank == 1'(b));
    always_ff @(posedge clk) begin
      if (wr_en)      mem[host_addr_i] <= host_data_i;
      if (fetch_en_i) rd_q <= mem[fetch_addr_i];
    end
  end

  // A boundary write to the entry being fetched lands in the bank going live.
  always_ff @(posedge clk) begin
    if (fetch_en_i) begin
      bsel_q     <= sel_nxt[fetch_addr_i];
      fwd_q      <= host_we_i && (host_addr_i == fetch_addr_i)
                    && (tgt_bank == sel_nxt[fetch_addr_i]);
      fwd_data_q <= host_data_i;
    end
  end

  assign word_o = fwd_q ? fwd_data_q : (bsel_q ? g_bank[1].rd_q : g_bank[0].rd_q);

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
    boundary_i |=> (pend_q == '0)); // R11
  AST_MIDFRAME_NO_SWAP: assert property (@(posedge clk) disable iff (rst)
    (!boundary_i && fetch_en_i) |=> (sel_q == $past(sel_q))); // R10

endmodule

// File: rtl/useq_addrgen.sv
module useq_addrgen #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 16,
  parameter int LFO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end_i,
  input  logic              issue_i,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic              lfo_en_i,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [LFO_W-1:0]  lfo_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] base_q, off_ext, lfo_ext, sum;
  logic              req_q, we_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)              base_q <= '0;
    else if (frame_end_i) base_q <= base_q - 1'b1;
  end

  assign off_ext = ADDR_W'(offset_i);
  assign lfo_ext = lfo_en_i ? ADDR_W'($signed(lfo_i)) : '0;
  assign sum     = base_q + off_ext + lfo_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q <= issue_i && acc_i;
      we_q  <= issue_i && acc_i && wr_i;
      if (issue_i && acc_i) addr_q <= sum;
    end
  end

  assign req_o  = req_q;
  assign we_o   = we_q;
  assign addr_o = addr_q;

  AST_BASE_STEP: assert property (@(posedge clk) disable iff (rst)
    frame_end_i |=> (base_q == $past(base_q) - 1'b1)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !req_q); // R12
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q); // R4

endmodule

// File: rtl/dsp_useq.sv
module dsp_useq #(
  parameter int N_INSTR = 64,
  parameter int N_PHASE = 8,
  parameter int ADDR_W  = 16,
  parameter int LFO_W   = 16,
  localparam int PC_W   = $clog2(N_INSTR),
  localparam int PH_W   = $clog2(N_PHASE),
  localparam int WORD_W = useq_pkg::UWORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we_i,
  input  logic [PC_W-1:0]   host_addr_i,
  input  logic [WORD_W-1:0] host_data_i,
  input  logic [LFO_W-1:0]  lfo_i,
  output logic              frame_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [WORD_W-1:0] instr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o
);

  import useq_pkg::*;

  logic [PC_W-1:0]   pc, fetch_addr;
  logic [PH_W-1:0]   phase;
  logic              fetch_en, frame_end, issue;
  logic [WORD_W-1:0] word_raw;
  uword_t            word;

  useq_timer #(.N_INSTR(N_INSTR), .N_PHASE(N_PHASE)) timer_i (
    .clk          (clk),
    .rst          (rst),
    .pc_o         (pc),
    .phase_o      (phase),
    .fetch_en_o   (fetch_en),
    .fetch_addr_o (fetch_addr),
    .frame_end_o  (frame_end),
    .issue_o      (issue)
  );

  useq_cstore #(.DEPTH(N_INSTR), .WORD_W(WORD_W)) cstore_i (
    .clk          (clk),
    .rst          (rst),
    .boundary_i   (frame_end),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_data_i  (host_data_i),
    .fetch_en_i   (fetch_en),
    .fetch_addr_i (fetch_addr),
    .word_o       (word_raw)
  );

  assign word = uword_t'(word_raw);

  useq_addrgen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .LFO_W(LFO_W)) addrgen_i (
    .clk         (clk),
    .rst         (rst),
    .frame_end_i (frame_end),
    .issue_i     (issue),
    .offset_i    (word.offset),
    .lfo_en_i    (word.lfo_en),
    .acc_i       (word.acc),
    .wr_i        (word.wr),
    .lfo_i       (lfo_i),
    .req_o       (mem_req_o),
    .we_o        (mem_we_o),
    .addr_o      (mem_addr_o)
  );

  assign frame_o = !rst && (pc == '0) && (phase == '0);
  assign pc_o    = pc;
  assign phase_o = phase;
  assign instr_o = word_raw;

  AST_REQ_PHASE: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (phase_o == PH_W'(1))); // R4
  AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_req_o); // R5
  AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_o |=> !frame_o); // R3

endmodule

// File: tb/dsp_useq_tb_top.sv
module dsp_useq_tb_top;

  localparam int NI = 64;
  localparam int NP = 8;
  localparam int FR = NI * NP;

  typedef struct packed {
    logic [5:0]  pc;
    logic [31:0] word;
    logic [15:0] lfo;
    logic        req;
    logic        we;
    logic [15:0] a0;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{6'd0,  32'h0005_2000, 16'h0000, 1'b1, 1'b0, 16'h0005},
    '{6'd2,  32'h0100_2000, 16'h5555, 1'b1, 1'b0, 16'h0100},
    '{6'd5,  32'h0040_6000, 16'h0000, 1'b1, 1'b1, 16'h0040},
    '{6'd9,  32'h1000_A000, 16'h0010, 1'b1, 1'b0, 16'h1010},
    '{6'd10, 32'h0000_E000, 16'hFFF0, 1'b1, 1'b1, 16'hFFF0},
    '{6'd20, 32'h1234_4000, 16'h0000, 1'b0, 1'b0, 16'h0000},
    '{6'd30, 32'h0008_3FFF, 16'h7777, 1'b1, 1'b0, 16'h0008},
    '{6'd63, 32'hFFFF_2000, 16'h0000, 1'b1, 1'b0, 16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_data = '0;
  logic [15:0] lfo = '0;
  logic        frame_o, mem_req_o, mem_we_o;
  logic [5:0]  pc_o;
  logic [2:0]  phase_o;
  logic [31:0] instr_o;
  logic [15:0] mem_addr_o;

  always #4 clk = ~clk;

  dsp_useq dut_i (
    .clk(clk), .rst(rst), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_data_i(host_data), .lfo_i(lfo), .frame_o(frame_o), .pc_o(pc_o),
    .phase_o(phase_o), .instr_o(instr_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
  );

  int checks = 0;
  int errors = 0;
  int tc = 0;
  bit done = 0;

  bit          e_req [NI], e_we [NI], pv [NI], p_req [NI], p_we [NI];
  logic [15:0] e_a0 [NI], p_a0 [NI], lfo_tab [NI];
  string       tag_of [NI], p_tag [NI];

  function automatic string vec_tag(int i);
    case (i)
      0: return "R6";
      2, 5: return "R5";
      6: return "R4";
      7: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (tc=%0d)", tag, what, act, exp, tc);
    end
  endtask

  // One cycle in reset with a host write; applies at once (R11, R12).
  task automatic reset_write(int a, logic [31:0] d, bit r, bit w, logic [15:0] a0, string tg);
    host_we = 1'b1; host_addr = 6'(a); host_data = d;
    e_req[a] = r; e_we[a] = w; e_a0[a] = a0; tag_of[a] = tg; pv[a] = 0;
    #1;
    chk("R12", "pc_in_reset", int'(pc_o), 0);
    chk("R12", "phase_in_reset", int'(phase_o), 0);
    chk("R12", "req_in_reset", int'(mem_req_o), 0);
    chk("R12", "frame_in_reset", int'(frame_o), 0);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic step(bit wr, int a, logic [31:0] d, bit r, bit w, logic [15:0] a0, string tg);
    int pc_e = (tc / NP) % NI;
    int ph_e = tc % NP;
    int f = tc / FR;
    logic [15:0] base = 16'(0 - f);
    lfo = lfo_tab[pc_e];
    host_we = wr; host_addr = 6'(a); host_data = d;
    if (wr) begin
      pv[a] = 1; p_req[a] = r; p_we[a] = w; p_a0[a] = a0; p_tag[a] = tg;
    end
    #1;
    chk("R3", "frame", int'(frame_o), int'(tc % FR == 0));
    chk("R1", "pc", int'(pc_o), pc_e);
    chk("R2", "phase", int'(phase_o), ph_e);
    if (ph_e == 1) begin
      chk(tag_of[pc_e], "req", int'(mem_req_o), int'(e_req[pc_e]));
      if (e_req[pc_e]) begin
        chk(tag_of[pc_e], "we", int'(mem_we_o), int'(e_we[pc_e]));
        chk(tag_of[pc_e], "addr", int'(mem_addr_o), int'(16'(e_a0[pc_e] + base)));
      end
    end else begin
      chk("R4", "req_off_phase", int'(mem_req_o), 0);
    end
    if (tc % FR == FR - 1) begin
      for (int i = 0; i < NI; i++) begin
        if (pv[i]) begin
          e_req[i] = p_req[i]; e_we[i] = p_we[i]; e_a0[i] = p_a0[i];
          tag_of[i] = p_tag[i]; pv[i] = 0;
        end
      end
    end
    tc++;
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(0, 0, 32'h0, 0, 0, 16'h0, "");
  endtask

  initial begin
    for (int i = 0; i < NI; i++) lfo_tab[i] = 16'h0;
    repeat (2) @(negedge clk);
    // Load: all entries no-op (R9), then the vector table.
    for (int i = 0; i < NI; i++) reset_write(i, 32'h0000_0303, 0, 0, 16'h0, "R9");
    for (int v = 0; v < 8; v++) begin
      lfo_tab[VEC[v].pc] = VEC[v].lfo;
      reset_write(int'(VEC[v].pc), VEC[v].word, VEC[v].req, VEC[v].we, VEC[v].a0, vec_tag(v));
    end
    rst = 1'b0;
    tc = 0;
    run(2 * FR);                       // frames 0 and 1: base 0 then 0xFFFF (R8)
    // R10: mid-frame write to entry 40, invisible until frame 3.
    run(32);
    step(1, 40, 32'h0200_2000, 1, 0, 16'h0200, "R10");
    run(FR - 1 - 33);
    // R11: write in the last cycle of frame 2 reaches entry 0 in frame 3.
    step(1, 0, 32'h0300_6000, 1, 1, 16'h0300, "R11");
    run(FR);
    // R12: reset mid-run keeps the program, clears the base.
    rst = 1'b1;
    @(negedge clk);
    reset_write(63, 32'h0000_0303, 0, 0, 16'h0, "R12");
    reset_write(20, 32'h1234_4000, 0, 0, 16'h0, "R12");
    rst = 1'b0;
    tc = 0;
    run(FR + 16);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule